// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache Core

This block holds the tag, state and data storage of a set-associative data cache and sequences its traffic to memory. The CPU side issues one request per cycle while the core is idle: a read lookup, a word write, a line allocate or a line clean. Every request carries a virtual address, which picks the set and the tag. An allocate also carries the physical address, which the line keeps so that later write-backs know where to go. Replacement uses a pointer per set that steps round-robin through the ways on every allocate.

Each line has two dirty flags, one for each half. A write-back therefore moves only the half or halves that changed. In write-back mode an allocate first flushes a dirty victim and then fills the new line one 32-bit word at a time over a single-outstanding request/acknowledge memory port. In write-through mode an allocate only installs the tag and the physical address, with no memory traffic. The way count, the set count and the words per line are parameters and must be powers of two; the line holds at least two words.

Top module: `cache_core`

## Requirements
- R1: After reset every line is invalid, so every read lookup misses, and `busy` and `memReq` are low.
- R2: A read lookup (reqOp 0) hits only if some way of the set selected by the address is valid and its stored line-aligned address equals the line-aligned request address. On a hit it returns the addressed word.
- R3: A write (reqOp 1) that hits stores the word and marks dirty the half line that holds it. A write that misses changes no state and starts no memory traffic.
- R4: Each set has its own victim pointer, starting at way 0. Every allocate (reqOp 2) replaces the pointed way and then advances the pointer by one, wrapping after the last way.
- R5: An allocate in write-back mode (wbMode high) fills the line with one read per word, at ascending consecutive word addresses starting at the line-aligned physical address. Later hits return the fetched words.
- R6: An allocate in write-through mode (wbMode low) makes no memory access and keeps `busy` low, yet the new address hits afterwards.
- R7: An allocate in write-back mode over a valid victim with any dirty half writes that data to the victim's stored physical address before the first fill read. A victim that is clean or invalid causes no writes.
- R8: A write-back covers only the dirty data. With only the lower half dirty it sends words 0 to half-1. With only the upper half dirty it sends the upper half, starting at the line base plus half a line. With both halves dirty it sends the whole line in ascending order.
- R9: A clean (reqOp 3) that hits a dirty line writes it back and then clears both dirty flags. The line stays valid, so a second clean sends nothing and reads still hit.
- R10: A clean that misses, or that hits a line with no dirty half, starts no memory traffic.
- R11: `busy` is high from the cycle after an accepted fill or write-back until the last word is acknowledged, and it implies `memReq`. The address and direction hold steady until the acknowledge. Requests presented while busy are ignored.
- R12: Each accepted request (reqValid high while busy is low) produces `respValid` in the next cycle, with the hit flag and the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbMode | input | 1 | 1 = write-back allocate (flush and fill), 0 = write-through allocate |
| reqValid | input | 1 | CPU request present |
| reqOp | input | 2 | 0 read, 1 write, 2 allocate, 3 clean |
| reqVaddr | input | 32 | Virtual address: set index, tag and word offset |
| reqPaddr | input | 32 | Physical address, used by allocate |
| reqWdata | input | 32 | Write data |
| busy | output | 1 | Memory sequence in progress; requests are not accepted |
| respValid | output | 1 | Response for the request accepted in the previous cycle |
| respHit | output | 1 | Lookup hit |
| respData | output | 32 | Addressed word on a hit |
| memReq | output | 1 | Memory word transaction pending |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Word address of the transaction |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Transaction completes in this cycle |
| memRdata | input | 32 | Read data, valid with memAck |

## Verification
The hardest case is an eviction that has to flush a dirty victim, because it needs a set whose pointer has wrapped back onto a filled line that a later write dirtied. The bench fills both ways of every set in write-back mode so that every pointer returns to way 0, dirties one half of a line in a chosen set, and then allocates a third address in that set. It checks that the memory log holds exactly the dirty half's writes followed by the four fill reads. The single-half write-back ranges are reached more directly, with a clean after writes to selected word offsets.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ALLOC = 2'd2,
    OP_CLEAN = 2'd3
  } cacheOp_e;

  // strobes from the sequencer to the storage datapath
  typedef struct packed {
    logic respond;     // register lookup result
    logic latch;       // capture set/way/addresses of the request
    logic useVictim;   // latch the round-robin way instead of the hit way
    logic cpuWrite;    // store CPU word into hit way, mark half dirty
    logic rrStep;      // advance the set's round-robin pointer
    logic installReq;  // install tag/pa from the live request
    logic installLat;  // install tag/pa from the latched request
    logic fillWrite;   // store memory word into latched line
    logic clearDirty;  // clear both dirty flags of latched line
    logic cntStep;     // next word
    logic cntClr;      // restart word counter
    logic wbPhase;     // memory port carries write-back traffic
  } ctrlStrobe_t;

endpackage

// File: rtl/cache_store.sv
module cache_store
  import cache_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 64,
  parameter int WPL  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t st,
  input  logic [31:0] reqVaddr,
  input  logic [31:0] reqPaddr,
  input  logic [31:0] reqWdata,
  input  logic [31:0] memRdata,
  output logic        anyHit,
  output logic [1:0]  hitDirty,
  output logic        vicValid,
  output logic [1:0]  vicDirty,
  output logic        cntLast,
  output logic        respValid,
  output logic        respHit,
  output logic [31:0] respData,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata
);
  localparam int WORD_BITS = $clog2(WPL);
  localparam int LINE_BITS = WORD_BITS + 2;
  localparam int SET_BITS  = $clog2(SETS);
  localparam int WAY_BITS  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W     = 32 - LINE_BITS;
  localparam int HALF      = WPL / 2;

  logic [WAYS-1:0]      validQ [SETS];
  logic [TAG_W-1:0]     tagQ   [SETS][WAYS];
  logic [TAG_W-1:0]     paQ    [SETS][WAYS];
  logic [1:0]           dirtyQ [SETS][WAYS];
  logic [WAY_BITS-1:0]  rrQ    [SETS];
  logic [31:0]          dataQ  [SETS][WAYS][WPL];

  logic [SET_BITS-1:0]  reqSet;
  logic [WORD_BITS-1:0] reqWord;
  logic [TAG_W-1:0]     reqTag;
  logic [WAYS-1:0]      hitVec;
  logic [WAY_BITS-1:0]  hitWay, victim, selWay;

  logic [SET_BITS-1:0]  latSet;
  logic [WAY_BITS-1:0]  latWay;
  logic [TAG_W-1:0]     latPaOld, latPaNew, latTag;
  logic [1:0]           latDirty;
  logic [WORD_BITS-1:0] cnt, wbStart, wbIdx;
  logic                 wbFull;

  assign reqSet  = reqVaddr[LINE_BITS+SET_BITS-1:LINE_BITS];
  assign reqWord = reqVaddr[LINE_BITS-1:2];
  assign reqTag  = reqVaddr[31:LINE_BITS];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validQ[reqSet][w] && (tagQ[reqSet][w] == reqTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitWay = WAY_BITS'(w);
  end

  assign anyHit   = |hitVec;
  assign hitDirty = dirtyQ[reqSet][hitWay];
  assign victim   = rrQ[reqSet];
  assign vicValid = validQ[reqSet][victim];
  assign vicDirty = dirtyQ[reqSet][victim];
  assign selWay   = st.useVictim ? victim : hitWay;

  // write-back window from the latched dirty flags (bit 0 lower half)
  assign wbFull  = &latDirty;
  assign wbStart = (latDirty == 2'b10) ? WORD_BITS'(HALF) : '0;
  assign wbIdx   = wbStart + cnt;
  assign cntLast = (st.wbPhase && !wbFull) ? (cnt == WORD_BITS'(HALF - 1))
                                           : (cnt == WORD_BITS'(WPL - 1));

  assign memAddr  = st.wbPhase ? {latPaOld, wbIdx, 2'b00} : {latPaNew, cnt, 2'b00};
  assign memWdata = dataQ[latSet][latWay][wbIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        rrQ[s]    <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tagQ[s][w]   <= '0;
          paQ[s][w]    <= '0;
          dirtyQ[s][w] <= '0;
        end
      end
      latSet    <= '0;
      latWay    <= '0;
      latPaOld  <= '0;
      latPaNew  <= '0;
      latTag    <= '0;
      latDirty  <= '0;
      cnt       <= '0;
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respData  <= '0;
    end else begin
      respValid <= st.respond;
      if (st.respond) begin
        respHit  <= anyHit;
        respData <= anyHit ? dataQ[reqSet][hitWay][reqWord] : '0;
      end
      if (st.rrStep)
        rrQ[reqSet] <= (rrQ[reqSet] == WAY_BITS'(WAYS - 1)) ? '0 : rrQ[reqSet] + 1'b1;
      if (st.cpuWrite)
        dirtyQ[reqSet][hitWay][reqWord[WORD_BITS-1]] <= 1'b1;
      if (st.installReq) begin
        validQ[reqSet][victim] <= 1'b1;
        tagQ[reqSet][victim]   <= reqTag;
        paQ[reqSet][victim]    <= reqPaddr[31:LINE_BITS];
        dirtyQ[reqSet][victim] <= '0;
      end
      if (st.installLat) begin
        validQ[latSet][latWay] <= 1'b1;
        tagQ[latSet][latWay]   <= latTag;
        paQ[latSet][latWay]    <= latPaNew;
        dirtyQ[latSet][latWay] <= '0;
      end
      if (st.clearDirty)
        dirtyQ[latSet][latWay] <= '0;
      if (st.latch) begin
        latSet   <= reqSet;
        latWay   <= selWay;
        latPaOld <= paQ[reqSet][selWay];
        latPaNew <= reqPaddr[31:LINE_BITS];
        latTag   <= reqTag;
        latDirty <= dirtyQ[reqSet][selWay];
      end
      if (st.cntClr)       cnt <= '0;
      else if (st.cntStep) cnt <= cnt + 1'b1;
    end
  end

  // line data: no reset, validity lives in validQ
  always_ff @(posedge clk) begin
    if (st.cpuWrite)  dataQ[reqSet][hitWay][reqWord] <= reqWdata;
    if (st.fillWrite) dataQ[latSet][latWay][cnt]     <= memRdata;
  end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wbMode,
  input  logic        reqValid,
  input  cacheOp_e    reqOp,
  input  logic        anyHit,
  input  logic [1:0]  hitDirty,
  input  logic        vicValid,
  input  logic [1:0]  vicDirty,
  input  logic        cntLast,
  input  logic        memAck,
  output ctrlStrobe_t st,
  output logic        busy,
  output logic        memReq,
  output logic        memWe
);
  typedef enum logic [1:0] {S_IDLE, S_WRBACK, S_FILL} seqState_e;

  seqState_e stateQ, stateD;
  logic      allocQ, allocD;

  always_comb begin
    st     = '0;
    stateD = stateQ;
    allocD = allocQ;
    unique case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          st.respond = 1'b1;
          allocD     = (reqOp == OP_ALLOC);
          unique case (reqOp)
            OP_WRITE: st.cpuWrite = anyHit;
            OP_ALLOC: begin
              st.rrStep    = 1'b1;
              st.latch     = 1'b1;
              st.useVictim = 1'b1;
              if (wbMode)
                stateD = (vicValid && |vicDirty) ? S_WRBACK : S_FILL;
              else
                st.installReq = 1'b1;
            end
            OP_CLEAN: begin
              st.latch = 1'b1;
              if (anyHit && |hitDirty) stateD = S_WRBACK;
            end
            default: ;
          endcase
        end
      end
      S_WRBACK: begin
        st.wbPhase = 1'b1;
        if (memAck) begin
          if (cntLast) begin
            st.cntClr = 1'b1;
            if (allocQ) stateD = S_FILL;
            else begin
              st.clearDirty = 1'b1;
              stateD        = S_IDLE;
            end
          end else st.cntStep = 1'b1;
        end
      end
      S_FILL: begin
        if (memAck) begin
          st.fillWrite = 1'b1;
          if (cntLast) begin
            st.cntClr     = 1'b1;
            st.installLat = 1'b1;
            stateD        = S_IDLE;
          end else st.cntStep = 1'b1;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      allocQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      allocQ <= allocD;
    end
  end

  assign busy   = (stateQ != S_IDLE);
  assign memReq = busy;
  assign memWe  = (stateQ == S_WRBACK);

endmodule

// File: rtl/cache_core.sv
module cache_core
  import cache_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 64,
  parameter int WPL  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wbMode,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [31:0] reqVaddr,
  input  logic [31:0] reqPaddr,
  input  logic [31:0] reqWdata,
  output logic        busy,
  output logic        respValid,
  output logic        respHit,
  output logic [31:0] respData,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memAck,
  input  logic [31:0] memRdata
);
  ctrlStrobe_t st;
  logic        anyHit, vicValid, cntLast;
  logic [1:0]  hitDirty, vicDirty;

  cache_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wbMode   (wbMode),
    .reqValid (reqValid),
    .reqOp    (cacheOp_e'(reqOp)),
    .anyHit   (anyHit),
    .hitDirty (hitDirty),
    .vicValid (vicValid),
    .vicDirty (vicDirty),
    .cntLast  (cntLast),
    .memAck   (memAck),
    .st       (st),
    .busy     (busy),
    .memReq   (memReq),
    .memWe    (memWe)
  );

  cache_store #(.WAYS(WAYS), .SETS(SETS), .WPL(WPL)) store_i (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .reqVaddr  (reqVaddr),
    .reqPaddr  (reqPaddr),
    .reqWdata  (reqWdata),
    .memRdata  (memRdata),
    .anyHit    (anyHit),
    .hitDirty  (hitDirty),
    .vicValid  (vicValid),
    .vicDirty  (vicDirty),
    .cntLast   (cntLast),
    .respValid (respValid),
    .respHit   (respHit),
    .respData  (respData),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );

endmodule

// File: rtl/cache_core_chk.sv
module cache_core_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wbMode,
  input logic        reqValid,
  input logic [1:0]  reqOp,
  input logic        busy,
  input logic        respValid,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic        memAck
);
  // R11
  memreq_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R11
  busy_ignores_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !respValid);

  // R12
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !busy |=> respValid);

  // R6
  wt_alloc_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !busy && reqOp == 2'd2 && !wbMode |=> !busy);

  // R2
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !busy && reqOp == 2'd0 |=> !busy);

  // R11
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);
endmodule

bind cache_core cache_core_chk chk_i (.*);

// File: tb/cache_core_tb_top.sv
module cache_core_tb_top;
  localparam int WAYS = 2;
  localparam int SETS = 4;
  localparam int WPL  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wbMode = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [31:0] reqVaddr = '0, reqPaddr = '0, reqWdata = '0;
  logic        busy, respValid, respHit, memReq, memWe;
  logic [31:0] respData, memAddr, memWdata, memRdata;
  logic        memAck = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] logAddr [64];
  logic [31:0] logData [64];
  logic        logWe   [64];
  int          logCnt = 0;
  int          logBase = 0;

  always #5 clk = ~clk;

  cache_core #(.WAYS(WAYS), .SETS(SETS), .WPL(WPL)) dut_i (
    .clk(clk), .rstN(rstN), .wbMode(wbMode), .reqValid(reqValid), .reqOp(reqOp),
    .reqVaddr(reqVaddr), .reqPaddr(reqPaddr), .reqWdata(reqWdata), .busy(busy),
    .respValid(respValid), .respHit(respHit), .respData(respData), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata));

  function automatic logic [31:0] memVal(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic logic [31:0] va(input int tag, input int s, input int w);
    return 32'(tag * 64 + s * 16 + w * 4);
  endfunction

  function automatic logic [31:0] pa(input int s, input int w);
    return 32'h0002_0000 + 32'(s * 256 + w * 64);
  endfunction

  assign memRdata = memVal(memAddr);

  // memory model: acknowledge every second cycle, log every transfer
  always @(posedge clk) begin
    memAck <= rstN && memReq && !memAck;
    if (memReq && memAck) begin
      if (logCnt < 64) begin
        logAddr[logCnt] <= memAddr;
        logData[logCnt] <= memWe ? memWdata : memRdata;
        logWe[logCnt]   <= memWe;
      end
      logCnt <= logCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [1:0] op, input logic [31:0] v, input logic [31:0] p,
                      input logic [31:0] wd, output logic hit, output logic [31:0] data,
                      output int busyCyc);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqVaddr = v; reqPaddr = p; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    check(respValid === 1'b1, "R12 respValid after accept", 32'(respValid), 32'd1);
    hit = respHit;
    data = respData;
    busyCyc = 0;
    while (busy) begin
      busyCyc++;
      @(negedge clk);
    end
  endtask

  task automatic markLog();
    logBase = logCnt;
  endtask

  task automatic expectEntry(input int i, input bit we, input logic [31:0] a,
                             input logic [31:0] d, input string tag);
    check(logWe[logBase+i] === we, {tag, " direction"}, 32'(logWe[logBase+i]), 32'(we));
    check(logAddr[logBase+i] === a, {tag, " address"}, logAddr[logBase+i], a);
    check(logData[logBase+i] === d, {tag, " data"}, logData[logBase+i], d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic h;
    logic [31:0] d;
    int bc;
    logic [31:0] dw [4];

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(busy === 1'b0, "R1 busy after reset", 32'(busy), 32'd0);
    check(memReq === 1'b0, "R1 memReq after reset", 32'(memReq), 32'd0);
    for (int s = 0; s < SETS; s++) begin
      doOp(2'd0, va(0, s, 0), '0, '0, h, d, bc);
      check(h === 1'b0, "R1 tag 0 lookup misses", 32'(h), 32'd0);
      doOp(2'd0, va(5, s, 2), '0, '0, h, d, bc);
      check(h === 1'b0, "R1 lookup misses", 32'(h), 32'd0);
    end

    // R3: write miss does nothing
    markLog();
    doOp(2'd1, va(1, 0, 0), '0, 32'hDEAD_0001, h, d, bc);
    check(h === 1'b0, "R3 write miss reported", 32'(h), 32'd0);
    doOp(2'd0, va(1, 0, 0), '0, '0, h, d, bc);
    check(h === 1'b0, "R3 no allocation on write miss", 32'(h), 32'd0);
    check(logCnt == logBase, "R3 no traffic on write miss", 32'(logCnt - logBase), 32'd0);

    // R6 + R4: write-through allocates, round-robin per set
    wbMode = 1'b0;
    markLog();
    for (int s = 0; s < SETS; s++) begin
      for (int t = 1; t <= 3; t++) begin
        doOp(2'd2, va(t, s, 0), pa(s, t), '0, h, d, bc);
        check(bc == 0, "R6 write-through allocate not busy", 32'(bc), 32'd0);
      end
      doOp(2'd0, va(1, s, 1), '0, '0, h, d, bc);
      check(h === 1'b0, "R4 third allocate evicts way 0", 32'(h), 32'd0);
      doOp(2'd0, va(2, s, 1), '0, '0, h, d, bc);
      check(h === 1'b1, "R6 R4 way 1 line resident", 32'(h), 32'd1);
      doOp(2'd0, va(3, s, 3), '0, '0, h, d, bc);
      check(h === 1'b1, "R6 newest line hits", 32'(h), 32'd1);
      doOp(2'd2, va(4, s, 0), pa(s, 0), '0, h, d, bc);
      doOp(2'd0, va(2, s, 1), '0, '0, h, d, bc);
      check(h === 1'b0, "R4 pointer wraps to way 1", 32'(h), 32'd0);
      doOp(2'd0, va(4, s, 2), '0, '0, h, d, bc);
      check(h === 1'b1, "R4 fourth allocate hits", 32'(h), 32'd1);
    end
    check(logCnt == logBase, "R6 no memory traffic", 32'(logCnt - logBase), 32'd0);

    // R5 + R2: write-back fills of both ways in every set (pointers back to 0)
    wbMode = 1'b1;
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        markLog();
        doOp(2'd2, va(8 + w, s, 0), pa(s, w) + 32'd12, '0, h, d, bc);
        check(bc == 2 * WPL, "R11 fill busy length", 32'(bc), 32'(2 * WPL));
        check(logCnt - logBase == WPL, "R5 fill word count", 32'(logCnt - logBase), 32'(WPL));
        for (int i = 0; i < WPL; i++)
          expectEntry(i, 1'b0, pa(s, w) + 32'(4 * i), memVal(pa(s, w) + 32'(4 * i)),
                      "R5 fill read");
      end
      for (int w = 0; w < WAYS; w++)
        for (int i = 0; i < WPL; i++) begin
          doOp(2'd0, va(8 + w, s, i), '0, '0, h, d, bc);
          check(h === 1'b1, "R2 filled line hits", 32'(h), 32'd1);
          check(d === memVal(pa(s, w) + 32'(4 * i)), "R2 R5 filled word", d,
                memVal(pa(s, w) + 32'(4 * i)));
        end
    end

    // R10: clean with nothing dirty, and clean on miss
    markLog();
    doOp(2'd3, va(8, 0, 0), '0, '0, h, d, bc);
    check(h === 1'b1 && bc == 0, "R10 clean of clean line idle", 32'(bc), 32'd0);
    doOp(2'd3, va(30, 0, 0), '0, '0, h, d, bc);
    check(h === 1'b0 && bc == 0, "R10 clean miss idle", 32'(bc), 32'd0);
    check(logCnt == logBase, "R10 no traffic", 32'(logCnt - logBase), 32'd0);

    // R8 lower half only, then R9
    for (int i = 0; i < WPL; i++) dw[i] = memVal(pa(0, 0) + 32'(4 * i));
    dw[1] = 32'hC0DE_0001;
    doOp(2'd1, va(8, 0, 1), '0, dw[1], h, d, bc);
    check(h === 1'b1, "R3 write hit", 32'(h), 32'd1);
    markLog();
    doOp(2'd3, va(8, 0, 0), '0, '0, h, d, bc);
    check(logCnt - logBase == 2, "R8 lower half count", 32'(logCnt - logBase), 32'd2);
    expectEntry(0, 1'b1, pa(0, 0), dw[0], "R8 lower half w0");
    expectEntry(1, 1'b1, pa(0, 0) + 32'd4, dw[1], "R8 lower half w1");
    markLog();
    doOp(2'd3, va(8, 0, 0), '0, '0, h, d, bc);
    check(logCnt == logBase, "R9 dirty cleared", 32'(logCnt - logBase), 32'd0);
    doOp(2'd0, va(8, 0, 1), '0, '0, h, d, bc);
    check(h === 1'b1 && d === dw[1], "R9 R3 line stays valid", d, dw[1]);

    // R8 upper half only
    dw[2] = 32'hC0DE_0002;
    doOp(2'd1, va(8, 0, 2), '0, dw[2], h, d, bc);
    markLog();
    doOp(2'd3, va(8, 0, 0), '0, '0, h, d, bc);
    check(logCnt - logBase == 2, "R8 upper half count", 32'(logCnt - logBase), 32'd2);
    expectEntry(0, 1'b1, pa(0, 0) + 32'd8, dw[2], "R8 upper half w2");
    expectEntry(1, 1'b1, pa(0, 0) + 32'd12, dw[3], "R8 upper half w3");

    // R8 both halves
    dw[0] = 32'hC0DE_0010;
    dw[3] = 32'hC0DE_0013;
    doOp(2'd1, va(8, 0, 3), '0, dw[3], h, d, bc);
    doOp(2'd1, va(8, 0, 0), '0, dw[0], h, d, bc);
    markLog();
    doOp(2'd3, va(8, 0, 0), '0, '0, h, d, bc);
    check(logCnt - logBase == WPL, "R8 full line count", 32'(logCnt - logBase), 32'(WPL));
    for (int i = 0; i < WPL; i++)
      expectEntry(i, 1'b1, pa(0, 0) + 32'(4 * i), dw[i], "R8 full line");

    // R7: allocate over dirty victim (set 1, way 0, upper half dirty)
    doOp(2'd1, va(8, 1, 3), '0, 32'hBEEF_0003, h, d, bc);
    markLog();
    doOp(2'd2, va(12, 1, 0), 32'h0003_0000, '0, h, d, bc);
    check(bc == 2 * (WPL / 2) + 2 * WPL, "R7 R11 evict busy length", 32'(bc),
          32'(2 * (WPL / 2) + 2 * WPL));
    check(logCnt - logBase == WPL / 2 + WPL, "R7 transfer count", 32'(logCnt - logBase),
          32'(WPL / 2 + WPL));
    expectEntry(0, 1'b1, pa(1, 0) + 32'd8, memVal(pa(1, 0) + 32'd8), "R7 victim w2");
    expectEntry(1, 1'b1, pa(1, 0) + 32'd12, 32'hBEEF_0003, "R7 victim w3");
    for (int i = 0; i < WPL; i++)
      expectEntry(2 + i, 1'b0, 32'h0003_0000 + 32'(4 * i), memVal(32'h0003_0000 + 32'(4 * i)),
                  "R7 fill after flush");
    doOp(2'd0, va(8, 1, 3), '0, '0, h, d, bc);
    check(h === 1'b0, "R7 victim gone", 32'(h), 32'd0);
    doOp(2'd0, va(12, 1, 2), '0, '0, h, d, bc);
    check(h === 1'b1 && d === memVal(32'h0003_0008), "R7 new line data", d,
          memVal(32'h0003_0008));

    // R7: clean victim in write-back mode gives no writes (set 1 way 1 is clean)
    markLog();
    doOp(2'd2, va(13, 1, 0), 32'h0003_0100, '0, h, d, bc);
    check(logCnt - logBase == WPL, "R7 clean victim only fill", 32'(logCnt - logBase), 32'(WPL));
    check(logWe[logBase] === 1'b0, "R7 clean victim first is read", 32'(logWe[logBase]), 32'd0);

    // R11: request while busy is ignored
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd2; reqVaddr = va(14, 2, 0); reqPaddr = 32'h0003_0200;
    @(negedge clk);
    reqOp = 2'd1; reqVaddr = va(9, 2, 0); reqWdata = 32'h1111_2222;
    check(busy === 1'b1, "R11 busy during fill", 32'(busy), 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    check(respValid === 1'b0, "R11 no response while busy", 32'(respValid), 32'd0);
    while (busy) @(negedge clk);
    doOp(2'd0, va(9, 2, 0), '0, '0, h, d, bc);
    check(h === 1'b1 && d === memVal(pa(2, 1)), "R11 write while busy ignored", d,
          memVal(pa(2, 1)));
    doOp(2'd0, va(14, 2, 1), '0, '0, h, d, bc);
    check(h === 1'b1 && d === memVal(32'h0003_0204), "R5 fill after busy test", d,
          memVal(32'h0003_0204));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule